// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Data Register Bank

This block holds the register state of a single-channel 64-position digital potentiometer. A volatile wiper counter picks the active tap. Four data registers stand in for non-volatile storage and hold saved wiper settings or general-purpose values. A serial front end decodes bus traffic and presents each command to this block as a one-cycle strobe. The strobe carries a 3-bit opcode, a register index and a data byte. Separate one-cycle step pulses move the wiper up or down.

The wiper has four load paths: a direct write from the host, a parallel copy from any data register, single-position steps, and an automatic load from register 0 after any reset. A read returns the wiper or a chosen data register one cycle after the command. Any command that changes a data register starts a persistent-write window of `NV_CYCLES` clock cycles, modelling a slow non-volatile write of up to 10 ms. While that window is open, `busy` is high and further data-register writes are dropped.

The controller is a three-state machine:
- **ST_PWRUP** is entered on any reset. It lasts one cycle and copies register 0 into the wiper (transition *pwrup_done* to ST_IDLE).
- **ST_IDLE** accepts every command. A data-register write takes transition *nv_start* to ST_NVWR.
- **ST_NVWR** times the persistent write. It accepts wiper and read commands and returns to ST_IDLE when its counter reaches zero (transition *nv_done*).

Top module: `pot_regbank`

## Requirements
- R1: Full reset (`rst_n` low) sets every data register to `DR_INIT`. One cycle after release, the wiper equals `DR_INIT`, `busy` is 0 and `rd_valid` is 0. `busy` is also high during the single power-up load cycle.
- R2: Wiper-only reset (`wiper_rst_n` low) keeps every data register. One cycle after release, the wiper equals the current content of register 0.
- R3: `tap_sel` has exactly one bit set, and that bit is the one at position equal to the wiper value.
- R4: Opcode 2 (write wiper) loads `cmd_data` into the wiper at the strobe edge.
- R5: Opcode 5 (register to wiper) copies data register `cmd_idx` into the wiper.
- R6: A step pulse with `step_up`=1 adds one to the wiper and stops at 63. A step pulse with `step_up`=0 subtracts one and stops at 0. The wiper never wraps.
- R7: Opcode 6 (wiper to register) copies the wiper into data register `cmd_idx` and starts a persistent write.
- R8: Opcode 4 writes `cmd_data` to data register `cmd_idx` and starts a persistent write. For reads, opcode 3 returns data register `cmd_idx` and opcode 1 returns the wiper. The result appears on `rd_data`, with `rd_valid` high, in the cycle after the strobe.
- R9: A persistent write holds `busy` high for exactly `NV_CYCLES` cycles, starting in the cycle after the strobe.
- R10: While `busy` is high from a persistent write, opcodes 4 and 6 are ignored. Opcodes 1, 2, 3 and 5 and step pulses still take effect.
- R11: Commands and steps in the power-up load cycle are ignored. A command strobe takes priority over a simultaneous step pulse, which is then dropped. Opcodes 0 and 7 change nothing and produce no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full synchronous reset, active low |
| wiper_rst_n | input | 1 | Wiper-only synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_idx | input | 2 | Data register index |
| cmd_data | input | 6 | Write data |
| step_valid | input | 1 | Single step pulse |
| step_up | input | 1 | Step direction, 1 = up |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 6 | Read result |
| busy | output | 1 | Power-up load or persistent write in progress |
| tap_sel | output | 64 | One-hot tap select |

## Verification
A wrong wiper value shows on `tap_sel` in the same cycle, because the decode is combinational from the counter. A fault in the step or load paths is therefore visible one edge after the offending command. A corrupted data register stays hidden until it is read or copied into the wiper, so the tests read back every register they touched. A timer fault shows as a `busy` window of the wrong length, or as a blocked write that was accepted anyway. The tests count the window to the exact cycle and probe writes issued while it is open.

// File: rtl/pot_pkg.sv
package pot_pkg;

    typedef enum logic [2:0] {
        OP_NOP          = 3'd0,
        OP_RD_WIPER     = 3'd1,
        OP_WR_WIPER     = 3'd2,
        OP_RD_REG       = 3'd3,
        OP_WR_REG       = 3'd4,
        OP_REG_TO_WIPER = 3'd5,
        OP_WIPER_TO_REG = 3'd6,
        OP_RSVD         = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_NVWR  = 2'd2
    } state_e;

endpackage

// File: rtl/pot_ctrl.sv
module pot_ctrl
    import pot_pkg::*;
#(
    parameter int NV_CYCLES = 1000000
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       step_valid,
    input  logic       step_up,
    output logic       wp_load,
    output logic       wp_from_reg,
    output logic       wp_step,
    output logic       wp_up,
    output logic       dr_we,
    output logic       dr_from_wiper,
    output logic       rd_en,
    output logic       rd_from_wiper,
    output logic       pwrup_load,
    output logic       busy
);

    localparam int CW = (NV_CYCLES > 1) ? $clog2(NV_CYCLES + 1) : 1;

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          start_nv;
    op_e           op;

    // State register and write-window timer
    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= ST_PWRUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_nv)
                cnt_q <= CW'(NV_CYCLES - 1);
            else if (state_q == ST_NVWR && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Next state and command decode
    always_comb begin
        op            = op_e'(cmd_op);
        state_d       = state_q;
        start_nv      = 1'b0;
        wp_load       = 1'b0;
        wp_from_reg   = 1'b0;
        wp_step       = 1'b0;
        wp_up         = 1'b0;
        dr_we         = 1'b0;
        dr_from_wiper = 1'b0;
        rd_en         = 1'b0;
        rd_from_wiper = 1'b0;
        pwrup_load    = 1'b0;
        unique case (state_q)
            ST_PWRUP: begin
                pwrup_load = 1'b1;
                state_d    = ST_IDLE;
            end
            ST_IDLE, ST_NVWR: begin
                if (state_q == ST_NVWR && cnt_q == '0)
                    state_d = ST_IDLE;
                if (cmd_valid) begin
                    case (op)
                        OP_RD_WIPER: begin
                            rd_en         = 1'b1;
                            rd_from_wiper = 1'b1;
                        end
                        OP_WR_WIPER: wp_load = 1'b1;
                        OP_RD_REG:   rd_en   = 1'b1;
                        OP_WR_REG: begin
                            if (state_q == ST_IDLE) begin
                                dr_we    = 1'b1;
                                start_nv = 1'b1;
                                state_d  = ST_NVWR;
                            end
                        end
                        OP_REG_TO_WIPER: begin
                            wp_load     = 1'b1;
                            wp_from_reg = 1'b1;
                        end
                        OP_WIPER_TO_REG: begin
                            if (state_q == ST_IDLE) begin
                                dr_we         = 1'b1;
                                dr_from_wiper = 1'b1;
                                start_nv      = 1'b1;
                                state_d       = ST_NVWR;
                            end
                        end
                        default: ;
                    endcase
                end else if (step_valid) begin
                    wp_step = 1'b1;
                    wp_up   = step_up;
                end
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    AST_NV_HOLD: assert property (@(posedge clk) disable iff (srst)
        (state_q == ST_NVWR && cnt_q != '0) |=> busy); // R9
    AST_NV_START: assert property (@(posedge clk) disable iff (srst)
        dr_we |=> (state_q == ST_NVWR)); // R9

endmodule

// File: rtl/pot_wiper.sv
module pot_wiper #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (srst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (step) begin
            if (up && q != MAXV)
                q <= q + 1'b1;
            else if (!up && q != '0)
                q <= q - 1'b1;
        end
    end

    AST_STEP_TOP: assert property (@(posedge clk) disable iff (srst)
        (step && !load && up && q == MAXV) |=> (q == MAXV)); // R6
    AST_STEP_BOTTOM: assert property (@(posedge clk) disable iff (srst)
        (step && !load && !up && q == '0) |=> (q == '0)); // R6

endmodule

// File: rtl/pot_dreg_bank.sv
module pot_dreg_bank #(
    parameter int W       = 6,
    parameter int NREG    = 4,
    parameter int DR_INIT = 32,
    localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          busy_i,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  d0
);

    logic [NREG-1:0][W-1:0] regs;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (clr)
                regs[i] <= W'(DR_INIT);
            else if (we && widx == IW'(i))
                regs[i] <= wdata;
        end
    end

    assign rdata = regs[ridx];
    assign d0    = regs[0];

    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (clr)
        we |-> !busy_i); // R10

endmodule

// File: rtl/pot_tap_decode.sv
module pot_tap_decode #(
    parameter int W    = 6,
    localparam int TAPS = 1 << W
) (
    input  logic [W-1:0]    sel,
    output logic [TAPS-1:0] tap
);

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap[i] = (sel == W'(i));
    end

endmodule

// File: rtl/pot_regbank.sv
module pot_regbank #(
    parameter int W         = 6,
    parameter int NREG      = 4,
    parameter int DR_INIT   = 32,
    parameter int NV_CYCLES = 1000000,
    localparam int IW       = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int TAPS     = 1 << W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wiper_rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [IW-1:0]   cmd_idx,
    input  logic [W-1:0]    cmd_data,
    input  logic            step_valid,
    input  logic            step_up,
    output logic            rd_valid,
    output logic [W-1:0]    rd_data,
    output logic            busy,
    output logic [TAPS-1:0] tap_sel
);

    logic srst, clr;
    logic wp_load, wp_from_reg, wp_step, wp_up;
    logic dr_we, dr_from_wiper, rd_en, rd_from_wiper, pwrup_load;
    logic [W-1:0] wiper_q, dr_rdata, dr_d0, wp_val, dr_wdata;

    assign srst = !rst_n || !wiper_rst_n;
    assign clr  = !rst_n;

    pot_ctrl #(.NV_CYCLES(NV_CYCLES)) u_ctrl (
        .clk(clk), .srst(srst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .step_valid(step_valid), .step_up(step_up),
        .wp_load(wp_load), .wp_from_reg(wp_from_reg),
        .wp_step(wp_step), .wp_up(wp_up),
        .dr_we(dr_we), .dr_from_wiper(dr_from_wiper),
        .rd_en(rd_en), .rd_from_wiper(rd_from_wiper),
        .pwrup_load(pwrup_load), .busy(busy)
    );

    assign wp_val   = pwrup_load ? dr_d0 : (wp_from_reg ? dr_rdata : cmd_data);
    assign dr_wdata = dr_from_wiper ? wiper_q : cmd_data;

    pot_wiper #(.W(W)) u_wiper (
        .clk(clk), .srst(srst),
        .load(wp_load || pwrup_load), .load_val(wp_val),
        .step(wp_step), .up(wp_up), .q(wiper_q)
    );

    pot_dreg_bank #(.W(W), .NREG(NREG), .DR_INIT(DR_INIT)) u_bank (
        .clk(clk), .clr(clr), .busy_i(busy),
        .we(dr_we), .widx(cmd_idx), .wdata(dr_wdata),
        .ridx(cmd_idx), .rdata(dr_rdata), .d0(dr_d0)
    );

    pot_tap_decode #(.W(W)) u_dec (
        .sel(wiper_q), .tap(tap_sel)
    );

    always_ff @(posedge clk) begin
        if (srst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= rd_from_wiper ? wiper_q : dr_rdata;
        end
    end

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (srst)
        $countones(tap_sel) == 1); // R3
    AST_PWRUP_LOAD: assert property (@(posedge clk) disable iff (srst)
        pwrup_load |=> (wiper_q == $past(dr_d0))); // R2

endmodule

// File: tb/sim_pot_regbank.sv
module sim_pot_regbank;

    localparam int NV   = 8;
    localparam int INIT = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, wiper_rst_n = 1'b1;
    logic        cmd_valid = 1'b0, step_valid = 1'b0, step_up = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_idx = '0;
    logic [5:0]  cmd_data = '0;
    logic        rd_valid, busy;
    logic [5:0]  rd_data;
    logic [63:0] tap_sel;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pot_regbank #(.DR_INIT(INIT), .NV_CYCLES(NV)) u0 (
        .clk(clk), .rst_n(rst_n), .wiper_rst_n(wiper_rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .step_valid(step_valid), .step_up(step_up),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .tap_sel(tap_sel)
    );

    // {req, op, idx, data, has_rd, exp_rd, exp_wiper}
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd4, 3'd2, 2'd0, 6'd10, 1'b0, 6'd0,  6'd10}, // R4
        {4'd8, 3'd1, 2'd0, 6'd0,  1'b1, 6'd10, 6'd10}, // R8
        {4'd8, 3'd4, 2'd1, 6'd45, 1'b0, 6'd0,  6'd10}, // R8
        {4'd8, 3'd3, 2'd1, 6'd0,  1'b1, 6'd45, 6'd10}, // R8
        {4'd5, 3'd5, 2'd1, 6'd0,  1'b0, 6'd0,  6'd45}, // R5
        {4'd4, 3'd2, 2'd0, 6'd3,  1'b0, 6'd0,  6'd3},  // R4
        {4'd7, 3'd6, 2'd2, 6'd0,  1'b0, 6'd0,  6'd3},  // R7
        {4'd7, 3'd3, 2'd2, 6'd0,  1'b1, 6'd3,  6'd3},  // R7
        {4'd5, 3'd5, 2'd0, 6'd0,  1'b0, 6'd0,  6'd21}, // R5
        {4'd1, 3'd3, 2'd3, 6'd0,  1'b1, 6'd21, 6'd21}  // R1
    };

    function automatic int tap_idx(input logic [63:0] t);
        int r = -1;
        for (int i = 0; i < 64; i++) if (t[i]) r = i;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [1:0] idx, input logic [5:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_step(input logic up, input int n);
        for (int i = 0; i < n; i++) begin
            step_valid = 1'b1; step_up = up;
            @(negedge clk);
            step_valid = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_reg(input logic [1:0] idx, input int exp, input string req);
        do_cmd(3'd3, idx, 6'd0);
        chk(req, "rd_valid", int'(rd_valid), 1);
        chk(req, "register readback", int'(rd_data), exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wiper after reset", tap_idx(tap_sel), INIT);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "rd_valid after reset", int'(rd_valid), 0);
        chk("R3", "tap ones", $countones(tap_sel), 1);

        for (int v = 0; v < NVEC; v++) begin
            logic [27:0] e;
            string req;
            e = VEC[v];
            req = $sformatf("R%0d", e[27:24]);
            do_cmd(e[23:21], e[20:19], e[18:13]);
            chk(req, "rd_valid", int'(rd_valid), int'(e[12]));
            if (e[12]) chk(req, "rd_data", int'(rd_data), int'(e[11:6]));
            chk(req, "wiper", tap_idx(tap_sel), int'(e[5:0]));
            wait_idle();
        end

        // R9 busy window length
        do_cmd(3'd4, 2'd0, 6'd50);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R9", "busy cycles", n, NV);

        // R10 writes ignored while busy; wiper ops still work
        do_cmd(3'd4, 2'd1, 6'd60);
        do_cmd(3'd4, 2'd3, 6'd33);
        do_cmd(3'd6, 2'd2, 6'd0);
        do_cmd(3'd2, 2'd0, 6'd7);
        chk("R10", "wiper write during busy", tap_idx(tap_sel), 7);
        chk("R10", "busy still high", int'(busy), 1);
        wait_idle();
        read_reg(2'd3, INIT, "R10");
        read_reg(2'd2, 3, "R10");
        read_reg(2'd1, 60, "R10");

        // R6 saturation
        do_cmd(3'd2, 2'd0, 6'd62);
        do_step(1'b1, 1);
        chk("R6", "step up", tap_idx(tap_sel), 63);
        do_step(1'b1, 2);
        chk("R6", "saturate high", tap_idx(tap_sel), 63);
        do_cmd(3'd2, 2'd0, 6'd1);
        do_step(1'b0, 3);
        chk("R6", "saturate low", tap_idx(tap_sel), 0);
        do_step(1'b1, 1);
        chk("R6", "step from zero", tap_idx(tap_sel), 1);

        // R11 command beats step; opcodes 0 and 7 inert
        step_valid = 1'b1; step_up = 1'b1;
        do_cmd(3'd1, 2'd0, 6'd0);
        step_valid = 1'b0;
        chk("R11", "step dropped", tap_idx(tap_sel), 1);
        chk("R11", "read with step", int'(rd_data), 1);
        do_cmd(3'd0, 2'd0, 6'd40);
        chk("R11", "op0 rd_valid", int'(rd_valid), 0);
        do_cmd(3'd7, 2'd1, 6'd40);
        chk("R11", "op7 rd_valid", int'(rd_valid), 0);
        chk("R11", "op7 wiper", tap_idx(tap_sel), 1);
        chk("R11", "op7 busy", int'(busy), 0);
        read_reg(2'd1, 60, "R11");

        // R2 wiper-only reset, command in power-up cycle ignored (R11)
        do_cmd(3'd2, 2'd0, 6'd5);
        wiper_rst_n = 1'b0;
        @(negedge clk);
        wiper_rst_n = 1'b1;
        do_cmd(3'd2, 2'd0, 6'd9);
        chk("R2", "wiper from reg0", tap_idx(tap_sel), 50);
        chk("R11", "command in power-up ignored", tap_idx(tap_sel), 50);
        chk("R2", "busy after wiper reset", int'(busy), 0);
        read_reg(2'd1, 60, "R2");

        // R1 full reset restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "wiper after full reset", tap_idx(tap_sel), INIT);
        read_reg(2'd0, INIT, "R1");
        read_reg(2'd1, INIT, "R1");
        chk("R3", "tap ones", $countones(tap_sel), 1);

        done = 1'b1;
        summary();
    end

endmodule